// File: doc/BRIEF.md
# Guest Timestamp Offset Unit

This block answers timestamp reads issued on behalf of a guest. It runs a free 64-bit cycle counter and holds a programmable signed 64-bit adjustment. Each read request names a read kind. Two plain control pins decide how the read is resolved. It either raises a trap, passes the raw counter through, or returns the counter plus the adjustment. The 64-bit result comes back as two 32-bit words.

Requests enter on a valid/ready channel and results leave on a second valid/ready channel, with one register stage between them. Back-pressure works as follows. The request side is ready only when the result register is empty or is being drained in the same cycle. While a result is held, its contents do not change. The adjustment is loaded through a plain one-cycle write strobe.

Top module: `gts_offset_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1. The counter restarts from 0.
- R2: The counter rises by exactly 1 on every clock edge after reset. A request accepted on an edge samples the counter value held before that edge's increment.
- R3: When `ctl_exit_on_read` is 1 for a handled request, the response has `rsp_trap`=1 and both value words are 0, whatever the value of `ctl_apply_offset`.
- R4: When `ctl_exit_on_read` is 0 and `ctl_apply_offset` is 1, the value is the counter plus the adjustment, taken as a two's-complement 64-bit sum.
- R5: When both controls are 0, the value is the raw counter, unchanged.
- R6: The sum wraps modulo 2^64. No flag reports overflow or underflow.
- R7: `rsp_hi` carries bits 63:32 of the value and `rsp_lo` carries bits 31:0, including any carry out of bit 31.
- R8: Kind codes 0 (plain read), 1 (read with processor identity) and 2 (register read) all obey R3 to R5 in the same way.
- R9: A request is not handled when it uses kind 2 with `req_index` different from `TS_REG_IDX` (default 32'h10), or when it uses kind 3. Its response has `rsp_unhandled`=1, `rsp_trap`=0 and zero value words, regardless of the controls.
- R10: A request accepted on an edge (`req_valid` and `req_ready` both 1) gives `rsp_valid`=1 after that edge. The response stays valid and unchanged until the edge on which `rsp_ready` is 1. `req_ready` equals `!rsp_valid || rsp_ready`.
- R11: An adjustment written on an edge applies to requests accepted on later edges. A request accepted on the same edge as the write uses the previous adjustment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_exit_on_read | input | 1 | Trap every handled read |
| ctl_apply_offset | input | 1 | Add the adjustment to the counter |
| ofs_wr_en | input | 1 | Load the adjustment |
| ofs_wr_data | input | 64 | New signed adjustment |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_kind | input | 2 | Read kind code |
| req_index | input | 32 | Register index for kind 2 |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_trap | output | 1 | Read must trap |
| rsp_unhandled | output | 1 | Request not handled by this block |
| rsp_hi | output | 32 | Value bits 63:32 |
| rsp_lo | output | 32 | Value bits 31:0 |

## Verification
Reads are issued under each of the four control combinations, so trapping, raw pass-through and adjusted values can be told apart. Every kind code is used, and kind 2 is sent with both a matching and a mismatching index. The adjustment values are chosen with a purpose: a small positive one, a negative one larger than the counter (which shows the wrap), and one that forces a carry from the low word into the high word (which shows the split). Back-to-back reads show that the counter advances exactly one step per cycle. A held response shows the back-pressure rules, and a write on the same edge as a read shows which adjustment that read uses.

// File: rtl/gts_pkg.sv
package gts_pkg;
  typedef enum logic [1:0] {
    RK_PLAIN   = 2'd0,
    RK_WITH_ID = 2'd1,
    RK_REG     = 2'd2,
    RK_RSVD    = 2'd3
  } rd_kind_e;

  typedef enum logic [1:0] {
    MD_SKIP = 2'd0,
    MD_TRAP = 2'd1,
    MD_RAW  = 2'd2,
    MD_ADJ  = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/gts_counter.sv
module gts_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gts_offset_reg.sv
module gts_offset_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ofs_o
);
  logic [W-1:0] ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     ofs_q <= '0;
    else if (wr_en) ofs_q <= wr_data;
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/gts_resolve.sv
module gts_resolve
  import gts_pkg::*;
#(
  parameter int          W          = 64,
  parameter int          SEG_W      = 16,
  parameter int          IDX_W      = 32,
  parameter logic [31:0] TS_REG_IDX = 32'h10
) (
  input  logic             exit_on_read,
  input  logic             apply_offset,
  input  logic [1:0]       kind,
  input  logic [IDX_W-1:0] index,
  input  logic [W-1:0]     cnt,
  input  logic [W-1:0]     ofs,
  output logic             trap_o,
  output logic             unhandled_o,
  output logic [W-1:0]     value_o
);
  localparam int NSEG = W / SEG_W;

  rd_kind_e     kind_e;
  rd_mode_e     mode;
  logic         handled;
  logic [W-1:0] sum;
  logic [NSEG-1:0] carry;

  assign kind_e = rd_kind_e'(kind);

  always_comb begin
    unique case (kind_e)
      RK_PLAIN, RK_WITH_ID: handled = 1'b1;
      RK_REG:               handled = (index == IDX_W'(TS_REG_IDX));
      default:              handled = 1'b0;
    endcase
  end

  always_comb begin
    if (!handled)          mode = MD_SKIP;
    else if (exit_on_read) mode = MD_TRAP;
    else if (apply_offset) mode = MD_ADJ;
    else                   mode = MD_RAW;
  end

  assign carry[0] = 1'b0;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g < NSEG - 1) begin : g_mid
      assign {carry[g+1], sum[g*SEG_W +: SEG_W]} =
        {1'b0, cnt[g*SEG_W +: SEG_W]} + {1'b0, ofs[g*SEG_W +: SEG_W]} +
        {{SEG_W{1'b0}}, carry[g]};
    end else begin : g_top
      assign sum[g*SEG_W +: SEG_W] =
        cnt[g*SEG_W +: SEG_W] + ofs[g*SEG_W +: SEG_W] +
        {{(SEG_W-1){1'b0}}, carry[g]};
    end
  end

  always_comb begin
    trap_o      = 1'b0;
    unhandled_o = 1'b0;
    value_o     = '0;
    unique case (mode)
      MD_SKIP: unhandled_o = 1'b1;
      MD_TRAP: trap_o      = 1'b1;
      MD_RAW:  value_o     = cnt;
      MD_ADJ:  value_o     = sum;
      default: value_o     = '0;
    endcase
  end
endmodule

// File: rtl/gts_rsp_stage.sv
module gts_rsp_stage #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_fire,
  output logic                in_ready,
  input  logic                in_trap,
  input  logic                in_unhandled,
  input  logic [2*WORD_W-1:0] in_value,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_trap,
  output logic                out_unhandled,
  output logic [WORD_W-1:0]   out_hi,
  output logic [WORD_W-1:0]   out_lo
);
  logic                valid_q;
  logic                trap_q;
  logic                unh_q;
  logic [2*WORD_W-1:0] value_q;

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      trap_q  <= 1'b0;
      unh_q   <= 1'b0;
      value_q <= '0;
    end else if (in_ready) begin
      valid_q <= in_fire;
      if (in_fire) begin
        trap_q  <= in_trap;
        unh_q   <= in_unhandled;
        value_q <= in_value;
      end
    end
  end

  assign out_valid     = valid_q;
  assign out_trap      = trap_q;
  assign out_unhandled = unh_q;
  assign out_hi        = value_q[2*WORD_W-1:WORD_W];
  assign out_lo        = value_q[WORD_W-1:0];
endmodule

// File: rtl/gts_offset_unit.sv
module gts_offset_unit #(
  parameter int          WORD_W     = 32,
  parameter int          SEG_W      = 16,
  parameter int          IDX_W      = 32,
  parameter logic [31:0] TS_REG_IDX = 32'h10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_exit_on_read,
  input  logic                ctl_apply_offset,
  input  logic                ofs_wr_en,
  input  logic [2*WORD_W-1:0] ofs_wr_data,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [IDX_W-1:0]    req_index,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic                rsp_trap,
  output logic                rsp_unhandled,
  output logic [WORD_W-1:0]   rsp_hi,
  output logic [WORD_W-1:0]   rsp_lo
);
  localparam int TS_W = 2 * WORD_W;

  logic [TS_W-1:0] cnt_q;
  logic [TS_W-1:0] ofs_q;
  logic            res_trap;
  logic            res_unh;
  logic [TS_W-1:0] res_value;
  logic            fire;

  gts_counter #(.W(TS_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt_q)
  );

  gts_offset_reg #(.W(TS_W)) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ofs_wr_en),
    .wr_data (ofs_wr_data),
    .ofs_o   (ofs_q)
  );

  gts_resolve #(
    .W          (TS_W),
    .SEG_W      (SEG_W),
    .IDX_W      (IDX_W),
    .TS_REG_IDX (TS_REG_IDX)
  ) u_res (
    .exit_on_read (ctl_exit_on_read),
    .apply_offset (ctl_apply_offset),
    .kind         (req_kind),
    .index        (req_index),
    .cnt          (cnt_q),
    .ofs          (ofs_q),
    .trap_o       (res_trap),
    .unhandled_o  (res_unh),
    .value_o      (res_value)
  );

  assign fire = req_valid && req_ready;

  gts_rsp_stage #(.WORD_W(WORD_W)) u_rsp (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_fire       (fire),
    .in_ready      (req_ready),
    .in_trap       (res_trap),
    .in_unhandled  (res_unh),
    .in_value      (res_value),
    .out_valid     (rsp_valid),
    .out_ready     (rsp_ready),
    .out_trap      (rsp_trap),
    .out_unhandled (rsp_unhandled),
    .out_hi        (rsp_hi),
    .out_lo        (rsp_lo)
  );
endmodule

// File: rtl/gts_offset_unit_chk.sv
module gts_offset_unit_chk #(
  parameter int          WORD_W     = 32,
  parameter int          IDX_W      = 32,
  parameter logic [31:0] TS_REG_IDX = 32'h10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctl_exit_on_read,
  input logic                req_valid,
  input logic                req_ready,
  input logic [1:0]          req_kind,
  input logic [IDX_W-1:0]    req_index,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic                rsp_trap,
  input logic                rsp_unhandled,
  input logic [WORD_W-1:0]   rsp_hi,
  input logic [WORD_W-1:0]   rsp_lo,
  input logic [2*WORD_W-1:0] cnt_q
);
  logic req_handled;
  assign req_handled = (req_kind == 2'd0) || (req_kind == 2'd1) ||
                       ((req_kind == 2'd2) && (req_index == IDX_W'(TS_REG_IDX)));

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_TRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap) |-> (rsp_hi == '0 && rsp_lo == '0)); // R3
  AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ctl_exit_on_read && req_handled) |=> (rsp_valid && rsp_trap)); // R3
  AST_UNHANDLED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_handled) |=> (rsp_valid && rsp_unhandled && !rsp_trap)); // R9
  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hi) && $stable(rsp_lo)
                                   && $stable(rsp_trap) && $stable(rsp_unhandled))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
endmodule

bind gts_offset_unit gts_offset_unit_chk #(
  .WORD_W     (WORD_W),
  .IDX_W      (IDX_W),
  .TS_REG_IDX (TS_REG_IDX)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .ctl_exit_on_read (ctl_exit_on_read),
  .req_valid        (req_valid),
  .req_ready        (req_ready),
  .req_kind         (req_kind),
  .req_index        (req_index),
  .rsp_valid        (rsp_valid),
  .rsp_ready        (rsp_ready),
  .rsp_trap         (rsp_trap),
  .rsp_unhandled    (rsp_unhandled),
  .rsp_hi           (rsp_hi),
  .rsp_lo           (rsp_lo),
  .cnt_q            (cnt_q)
);

// File: tb/tb_gts_offset_unit.sv
`timescale 1ns/1ps
module tb_gts_offset_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_exit_on_read = 1'b0;
  logic        ctl_apply_offset = 1'b0;
  logic        ofs_wr_en = 1'b0;
  logic [63:0] ofs_wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_index = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_trap;
  logic        rsp_unhandled;
  logic [31:0] rsp_hi;
  logic [31:0] rsp_lo;

  gts_offset_unit dut (.*);

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic        trap;
    logic        unh;
    logic [63:0] val;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] tb_cnt = '0;
  logic [63:0] tb_ofs = '0;
  bit          done = 0;

  always @(posedge clk) begin
    if (!rst_n) tb_cnt <= '0;
    else        tb_cnt <= tb_cnt + 64'd1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #(CLK_P/4);
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual unexpected response expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " trap"}, {63'd0, rsp_trap}, {63'd0, e.trap});
        check({e.tag, " unhandled"}, {63'd0, rsp_unhandled}, {63'd0, e.unh});
        check({e.tag, " value"}, {rsp_hi, rsp_lo}, e.val);
      end
    end
  end

  // Driver: call at a negedge, returns at the negedge after acceptance.
  task automatic do_req(input logic [1:0] kind, input logic [31:0] idx, input string tag);
    exp_t e;
    req_valid = 1'b1;
    req_kind  = kind;
    req_index = idx;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    e.tag = tag;
    e.trap = 1'b0; e.unh = 1'b0; e.val = '0;
    if (kind == 2'd3 || (kind == 2'd2 && idx != 32'h10)) e.unh = 1'b1;
    else if (ctl_exit_on_read) e.trap = 1'b1;
    else if (ctl_apply_offset) e.val = tb_cnt + tb_ofs;
    else e.val = tb_cnt;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ofs(input logic [63:0] v);
    ofs_wr_en = 1'b1; ofs_wr_data = v;
    @(negedge clk);
    ofs_wr_en = 1'b0;
    tb_ofs = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] held_hi, held_lo;
    repeat (4) @(negedge clk);
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    check("R1 req_ready after reset", {63'd0, req_ready}, 64'd1);

    // raw reads, back to back
    do_req(2'd0, 32'h0, "R5 raw plain");
    do_req(2'd0, 32'h0, "R2 raw next cycle");
    do_req(2'd1, 32'h0, "R2 raw with id");
    idle(2);

    // positive adjustment on all kinds
    wr_ofs(64'd1000);
    ctl_apply_offset = 1'b1;
    do_req(2'd0, 32'h0, "R4 adj plain");
    do_req(2'd1, 32'h0, "R8 adj with id");
    do_req(2'd2, 32'h10, "R8 adj reg");
    idle(1);

    // negative adjustment larger than the counter: wraps
    wr_ofs(64'hFFFF_FFFF_FFF0_0000);
    do_req(2'd2, 32'h10, "R6 wrap negative");
    idle(1);
    wr_ofs(64'h7FFF_FFFF_FFFF_FFFF);
    do_req(2'd0, 32'h0, "R6 wrap positive");
    idle(1);

    // carry from low word into high word
    wr_ofs(64'h0000_0001_FFFF_FFFF);
    do_req(2'd1, 32'h0, "R7 carry into hi");
    idle(1);

    // trapping regardless of apply control
    ctl_exit_on_read = 1'b1;
    do_req(2'd0, 32'h0, "R3 trap apply=1");
    ctl_apply_offset = 1'b0;
    do_req(2'd2, 32'h10, "R3 trap apply=0");
    idle(1);

    // not handled
    do_req(2'd2, 32'h11, "R9 wrong index exit=1");
    ctl_exit_on_read = 1'b0;
    do_req(2'd2, 32'h0, "R9 wrong index raw");
    ctl_apply_offset = 1'b1;
    do_req(2'd3, 32'h10, "R9 reserved kind");
    idle(1);

    // write on same edge as request: old adjustment used, then new
    ofs_wr_en = 1'b1; ofs_wr_data = 64'd5;
    do_req(2'd0, 32'h0, "R11 same-edge old offset");
    ofs_wr_en = 1'b0; tb_ofs = 64'd5;
    do_req(2'd0, 32'h0, "R11 next uses new offset");
    idle(1);

    // back-pressure
    rsp_ready = 1'b0;
    do_req(2'd0, 32'h0, "R10 stalled response");
    req_valid = 1'b0;
    #1;
    check("R10 valid while stalled", {63'd0, rsp_valid}, 64'd1);
    check("R10 req_ready low while stalled", {63'd0, req_ready}, 64'd0);
    held_hi = rsp_hi; held_lo = rsp_lo;
    repeat (3) @(negedge clk);
    #1;
    check("R10 value held", {rsp_hi, rsp_lo}, {held_hi, held_lo});
    rsp_ready = 1'b1;
    @(negedge clk);
    #(CLK_P/2);
    check("R10 valid drops after take", {63'd0, rsp_valid}, 64'd0);
    idle(2);

    check("R10 scoreboard drained", 64'(sb.size()), 64'd0);
    finish_run();
  end
endmodule